// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port with Byte Queues and Handshake

This block is the asynchronous serial port that a modem presents to its host processor. It holds a transmitter and a receiver, each behind its own 16-entry queue. The CPU side writes bytes into the transmit queue and pops received bytes, together with their error flags, from the head of the receive queue. Level and full/empty flags are provided for both queues.

Static configuration inputs select the character format: a data length of five to eight bits, a stop length of one, one and a half or two bit times, and parity of none, odd, even or a fixed-value ("sticky") bit. A divisor sets the rate of an oversampling tick that runs at sixteen times the bit rate. Both directions use this tick.

Two handshake lines can pace the link. Each direction can enable its own automatic flow control. The receiver also reports framing errors, parity errors and line breaks.

Top module: `uart_hsif`

## Requirements
- R1: Each queue holds 16 bytes. `tx_full` is high and `tx_level` reads 16 once 16 bytes are waiting. A write to a full transmit queue is discarded. After reset both levels are 0, `rx_empty` is 1 and `txd` is 1.
- R2: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are sent least significant bit first. One bit time is 16 ticks, and one tick is `cfg_div` clock cycles. A received value carries only the selected number of bits, and the upper bits are zero.
- R3: Each frame begins with a single low start bit of 16 ticks. The receiver drops a start bit when the line is high again 8 ticks after the falling edge, and then pushes nothing.
- R4: `cfg_stop` selects the stop length: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 gives 32 ticks. `tx_busy` is high for exactly the frame length in clock cycles.
- R5: With `cfg_par_en`=1 and `cfg_par_stick`=0, one parity bit follows the data. The bit makes the count of ones odd when `cfg_par_odd`=1 and even when `cfg_par_odd`=0. A received parity bit that does not match sets `rx_perr` on that entry.
- R6: With `cfg_par_en`=1 and `cfg_par_stick`=1, the parity bit is a constant equal to `cfg_par_odd`. A received bit that differs from that constant sets `rx_perr`.
- R7: With `cfg_afc_tx`=1, no frame starts while `hs_in` is 0. Waiting bytes stay queued and `txd` stays high.
- R8: With `cfg_afc_rx`=1, `hs_out` is 0 while 14 or more entries wait in the receive queue, and 1 otherwise. With `cfg_afc_rx`=0, `hs_out` is 1. The output is registered, so it follows the level one cycle later.
- R9: If the line stays low through the start bit, all data bits, the parity bit and the first stop bit, one entry with data 0 and `rx_brk`=1 is pushed. The receiver then waits for the line to go high before it looks for another start bit.
- R10: A stop bit sampled low, when the frame is not a break, sets `rx_ferr` on that entry. The receiver then waits for the line to go high.
- R11: The receive queue keeps arrival order. `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` show the oldest entry, and `rx_rd` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_len | input | 2 | Data length select |
| cfg_stop | input | 2 | Stop length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity, or constant value 1 when sticky |
| cfg_par_stick | input | 1 | Parity bit is a constant |
| cfg_div | input | DIV_W | Clock cycles per oversample tick |
| cfg_afc_tx | input | 1 | Transmit waits for hs_in |
| cfg_afc_rx | input | 1 | hs_out follows receive queue fill |
| tx_wr | input | 1 | Push tx_data into transmit queue |
| tx_data | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | clog2(FIFO_DEPTH+1) | Transmit queue fill |
| tx_busy | output | 1 | A frame is on the line |
| rx_rd | input | 1 | Pop receive queue head |
| rx_data | output | 8 | Head data |
| rx_perr | output | 1 | Head parity error |
| rx_ferr | output | 1 | Head framing error |
| rx_brk | output | 1 | Head is a break |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | clog2(FIFO_DEPTH+1) | Receive queue fill |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| hs_in | input | 1 | Peer ready to accept (active high) |
| hs_out | output | 1 | Block ready to accept (active high) |

## Verification
On every cycle, the checker confirms the following. Queue fills stay within depth and the receive fill moves by at most one per cycle. The line idles high whenever no frame is in flight. A frame never starts when the handshake gate was closed on the previous cycle. `hs_out` matches the receive fill threshold one cycle later. A break entry at the queue head always carries zero data.

Some properties are only visible through the bench's scenarios. These are the correctness of data bits, the parity value for each format and the exact frame lengths for 1.5 and 2 stop bits. The same holds for rejecting a short start glitch, reporting parity, framing and break errors on hand-built line waveforms, and dropping the seventeenth write.

// File: rtl/uart_hsif_pkg.sv
package uart_hsif_pkg;

   localparam int DATA_W = 8;
   localparam int RXW    = DATA_W + 3;   // {brk, ferr, perr, data}

   typedef enum logic [2:0] {
      LS_IDLE, LS_START, LS_DATA, LS_PAR, LS_STOP, LS_HOLD
   } line_st_t;

   typedef struct packed {
      logic [1:0] len;
      logic       par_en;
      logic       par_odd;
      logic       par_stick;
   } par_cfg_t;

   typedef struct packed {
      par_cfg_t   pc;
      logic [1:0] stop;
   } frame_cfg_t;

   function automatic int data_bits(logic [1:0] len);
      return 5 + int'(len);
   endfunction

   function automatic logic [DATA_W-1:0] len_mask(logic [1:0] len);
      return DATA_W'((1 << data_bits(len)) - 1);
   endfunction

   // parity bit to send / expect for a given character
   function automatic logic par_calc(par_cfg_t c, logic [DATA_W-1:0] d);
      if (c.par_stick) return c.par_odd;
      return (^(d & len_mask(c.len))) ^ c.par_odd;
   endfunction

   // stop length in oversample ticks
   function automatic int stop_ticks(logic [1:0] sel, int ovs);
      case (sel)
         2'd0:    return ovs;
         2'd1:    return ovs + ovs / 2;
         default: return 2 * ovs;
      endcase
   endfunction

endpackage

// File: rtl/uart_hsif_fifo.sv
module uart_hsif_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("uart_hsif_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/uart_hsif_tick.sv
module uart_hsif_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   // divisor 0 and 1 both give a tick every cycle
   assign wrap = (div <= DIV_W'(1)) || (cnt >= div - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         cnt  <= wrap ? '0 : cnt + 1'b1;
         tick <= wrap;
      end
   end
endmodule

// File: rtl/uart_hsif_tx.sv
module uart_hsif_tx
   import uart_hsif_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  frame_cfg_t        cfg,
   input  logic              avail,
   input  logic [DATA_W-1:0] din,
   input  logic              send_ok,
   output logic              pop,
   output logic              txd,
   output logic              busy
);
   localparam int TCW = $clog2(2 * OVS);
   localparam int BW  = $clog2(DATA_W);

   line_st_t          st;
   logic [TCW-1:0]    tcnt, last;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] sh;
   logic              pbit, last_bit;

   assign pop      = (st == LS_IDLE) && tick && avail && send_ok;
   assign busy     = (st != LS_IDLE);
   assign last_bit = (int'(bidx) == data_bits(cfg.pc.len) - 1);

   always_comb begin
      if (st == LS_STOP) last = TCW'(stop_ticks(cfg.stop, OVS) - 1);
      else               last = TCW'(OVS - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= LS_IDLE;
         txd  <= 1'b1;
         tcnt <= '0;
         bidx <= '0;
         sh   <= '0;
         pbit <= 1'b0;
      end else if (st == LS_IDLE) begin
         if (pop) begin
            st   <= LS_START;
            txd  <= 1'b0;
            tcnt <= '0;
            sh   <= din;
            pbit <= par_calc(cfg.pc, din);
         end
      end else if (tick) begin
         if (tcnt != last) begin
            tcnt <= tcnt + 1'b1;
         end else begin
            tcnt <= '0;
            case (st)
               LS_START: begin
                  st   <= LS_DATA;
                  bidx <= '0;
                  txd  <= sh[0];
               end
               LS_DATA: begin
                  if (last_bit) begin
                     st  <= cfg.pc.par_en ? LS_PAR : LS_STOP;
                     txd <= cfg.pc.par_en ? pbit : 1'b1;
                  end else begin
                     bidx <= bidx + 1'b1;
                     sh   <= sh >> 1;
                     txd  <= sh[1];
                  end
               end
               LS_PAR: begin
                  st  <= LS_STOP;
                  txd <= 1'b1;
               end
               default: begin
                  st  <= LS_IDLE;
                  txd <= 1'b1;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_hsif_rx.sv
module uart_hsif_rx
   import uart_hsif_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  par_cfg_t       cfg,
   input  logic           line,
   output logic           push,
   output logic [RXW-1:0] word
);
   localparam int TCW  = $clog2(OVS);
   localparam int BW   = $clog2(DATA_W);
   localparam int HALF = OVS / 2;

   line_st_t          st;
   logic [TCW-1:0]    tcnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] sh;
   logic              prx, allz, mid, last_bit;

   assign mid      = tick && (tcnt == TCW'(OVS - 1));
   assign last_bit = (int'(bidx) == data_bits(cfg.len) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= LS_IDLE;
         tcnt <= '0;
         bidx <= '0;
         sh   <= '0;
         prx  <= 1'b0;
         allz <= 1'b0;
         push <= 1'b0;
         word <= '0;
      end else begin
         push <= 1'b0;
         if (tick && st != LS_IDLE && st != LS_HOLD && !mid) tcnt <= tcnt + 1'b1;
         case (st)
            LS_IDLE: begin
               if (tick && !line) begin
                  st   <= LS_START;
                  tcnt <= '0;
               end
            end
            LS_START: begin
               if (tick && tcnt == TCW'(HALF - 1)) begin
                  tcnt <= '0;
                  bidx <= '0;
                  sh   <= '0;
                  allz <= 1'b1;
                  st   <= line ? LS_IDLE : LS_DATA;
               end
            end
            LS_DATA: begin
               if (mid) begin
                  tcnt     <= '0;
                  sh[bidx] <= line;
                  allz     <= allz & !line;
                  if (last_bit) st <= cfg.par_en ? LS_PAR : LS_STOP;
                  else          bidx <= bidx + 1'b1;
               end
            end
            LS_PAR: begin
               if (mid) begin
                  tcnt <= '0;
                  prx  <= line;
                  allz <= allz & !line;
                  st   <= LS_STOP;
               end
            end
            LS_STOP: begin
               if (mid) begin
                  tcnt <= '0;
                  push <= 1'b1;
                  if (!line && allz) begin
                     word <= {1'b1, 1'b0, 1'b0, {DATA_W{1'b0}}};
                     st   <= LS_HOLD;
                  end else begin
                     word <= {1'b0, !line, cfg.par_en && (prx != par_calc(cfg, sh)), sh};
                     st   <= line ? LS_IDLE : LS_HOLD;
                  end
               end
            end
            default: begin
               if (line) st <= LS_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/uart_hsif.sv
module uart_hsif
   import uart_hsif_pkg::*;
#(
   parameter int FIFO_DEPTH  = 16,
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int RTS_LEVEL   = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [1:0]                      cfg_len,
   input  logic [1:0]                      cfg_stop,
   input  logic                            cfg_par_en,
   input  logic                            cfg_par_odd,
   input  logic                            cfg_par_stick,
   input  logic [DIV_W-1:0]                cfg_div,
   input  logic                            cfg_afc_tx,
   input  logic                            cfg_afc_rx,
   input  logic                            tx_wr,
   input  logic [7:0]                      tx_data,
   output logic                            tx_full,
   output logic [$clog2(FIFO_DEPTH+1)-1:0] tx_level,
   output logic                            tx_busy,
   input  logic                            rx_rd,
   output logic [7:0]                      rx_data,
   output logic                            rx_perr,
   output logic                            rx_ferr,
   output logic                            rx_brk,
   output logic                            rx_empty,
   output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
   output logic                            txd,
   input  logic                            rxd,
   input  logic                            hs_in,
   output logic                            hs_out
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   if (RTS_LEVEL < 1 || RTS_LEVEL > FIFO_DEPTH) begin : g_bad_rts
      $error("uart_hsif: RTS_LEVEL out of range");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("uart_hsif: OVS must be even and at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("uart_hsif: SYNC_STAGES must be at least 1");
   end

   frame_cfg_t     cfg;
   logic           tick, line_s;
   logic           tx_empty, tx_pop;
   logic [7:0]     tx_head;
   logic           rx_push;
   logic [RXW-1:0] rx_word, rx_head;

   assign cfg.pc.len       = cfg_len;
   assign cfg.pc.par_en    = cfg_par_en;
   assign cfg.pc.par_odd   = cfg_par_odd;
   assign cfg.pc.par_stick = cfg_par_stick;
   assign cfg.stop         = cfg_stop;

   // input synchronizer, depth chosen by parameter
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
         if (!rst_n) line_s <= 1'b1;
         else        line_s <= rxd;
      end
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk) begin
         if (!rst_n) sq <= '1;
         else        sq <= {sq[SYNC_STAGES-2:0], rxd};
      end
      assign line_s = sq[SYNC_STAGES-1];
   end

   uart_hsif_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
   );

   uart_hsif_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(tx_data), .pop(tx_pop),
      .dout(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level)
   );

   uart_hsif_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .avail(!tx_empty),
      .din(tx_head), .send_ok(!cfg_afc_tx || hs_in), .pop(tx_pop),
      .txd(txd), .busy(tx_busy)
   );

   uart_hsif_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg.pc), .line(line_s),
      .push(rx_push), .word(rx_word)
   );

   uart_hsif_fifo #(.W(RXW), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rx_rd),
      .dout(rx_head), .full(), .empty(rx_empty), .level(rx_level)
   );

   assign {rx_brk, rx_ferr, rx_perr, rx_data} = rx_head;

   always_ff @(posedge clk) begin
      if (!rst_n) hs_out <= 1'b1;
      else        hs_out <= !(cfg_afc_rx && rx_level >= CW'(RTS_LEVEL));
   end
endmodule

// File: rtl/uart_hsif_chk.sv
module uart_hsif_chk #(
   parameter int FIFO_DEPTH = 16,
   parameter int RTS_LEVEL  = 14
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cfg_afc_tx,
   input logic                            cfg_afc_rx,
   input logic                            hs_in,
   input logic                            hs_out,
   input logic                            tx_busy,
   input logic                            txd,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] tx_level,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
   input logic                            rx_empty,
   input logic                            rx_brk,
   input logic [7:0]                      rx_data
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   p_lvl_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= CW'(FIFO_DEPTH) && rx_level <= CW'(FIFO_DEPTH));

   p_rx_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level == $past(rx_level) || rx_level == $past(rx_level) + 1'b1
      || rx_level + 1'b1 == $past(rx_level));

   p_idle_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(!cfg_afc_tx || hs_in));

   p_rts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_afc_rx && rx_level >= CW'(RTS_LEVEL)) |-> !hs_out);

   p_rts_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cfg_afc_rx || rx_level < CW'(RTS_LEVEL)) |-> hs_out);

   p_brk_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_empty && rx_brk) |-> rx_data == 8'h00);
endmodule

bind uart_hsif uart_hsif_chk #(.FIFO_DEPTH(FIFO_DEPTH), .RTS_LEVEL(RTS_LEVEL)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_afc_tx(cfg_afc_tx), .cfg_afc_rx(cfg_afc_rx),
   .hs_in(hs_in), .hs_out(hs_out), .tx_busy(tx_busy), .txd(txd),
   .tx_level(tx_level), .rx_level(rx_level), .rx_empty(rx_empty),
   .rx_brk(rx_brk), .rx_data(rx_data)
);

// File: tb/uart_hsif_bench.sv
module uart_hsif_bench;
   localparam int DIV = 2;
   localparam int BIT = 16 * DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0;
   logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_par_stick = 1'b0;
   logic [15:0] cfg_div = 16'(DIV);
   logic cfg_afc_tx = 1'b0, cfg_afc_rx = 1'b0;
   logic tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic tx_full, tx_busy, rx_rd, rx_perr, rx_ferr, rx_brk, rx_empty, txd, rxd, hs_out;
   logic [4:0] tx_level, rx_level;
   logic [7:0] rx_data;
   logic hs_in = 1'b1;
   logic loop_en = 1'b1, line_drv = 1'b1;
   logic mon_en = 1'b1;
   int   pop_budget = 0;
   int   nchk = 0, nbad = 0;
   logic [10:0] exp_q[$];

   assign rxd = loop_en ? txd : line_drv;
   always #4 clk = ~clk;

   uart_hsif u_uart_hsif (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_stop(cfg_stop),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_par_stick(cfg_par_stick),
      .cfg_div(cfg_div), .cfg_afc_tx(cfg_afc_tx), .cfg_afc_rx(cfg_afc_rx),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .tx_level(tx_level),
      .tx_busy(tx_busy), .rx_rd(rx_rd), .rx_data(rx_data), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_empty(rx_empty), .rx_level(rx_level),
      .txd(txd), .rxd(rxd), .hs_in(hs_in), .hs_out(hs_out)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   endtask

   // monitor: pops the receive queue head and compares it with the scoreboard
   initial begin
      rx_rd = 1'b0;
      forever begin
         @(negedge clk);
         rx_rd = 1'b0;
         if (rst_n && !rx_empty && (mon_en || pop_budget > 0)) begin
            if (exp_q.size() == 0) begin
               chk("R11 unexpected entry", {21'd0, rx_brk, rx_ferr, rx_perr, rx_data}, 32'hFFFF);
            end else begin
               chk("R2 R5 R6 R9 R10 R11 rx entry",
                   {21'd0, rx_brk, rx_ferr, rx_perr, rx_data}, {21'd0, exp_q.pop_front()});
            end
            rx_rd = 1'b1;
            if (pop_budget > 0) pop_budget--;
         end
      end
   end

   function automatic logic [7:0] masked(logic [7:0] b);
      logic [7:0] m;
      m = (8'd1 << (5 + cfg_len)) - 8'd1;
      if (cfg_len == 2'd3) m = 8'hFF;
      return b & m;
   endfunction

   task automatic send(logic [7:0] b);
      exp_q.push_back({3'b000, masked(b)});
      @(negedge clk);
      while (tx_full) @(negedge clk);
      tx_wr = 1'b1;
      tx_data = b;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic drain;
      int n = 0;
      @(negedge clk);
      while ((exp_q.size() != 0 || tx_busy || tx_level != 0) && n < 40000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 40000) chk("R11 drain timeout", 32'd1, 32'd0);
      repeat (BIT) @(negedge clk);
   endtask

   task automatic setcfg(int len, int stp, int pm);
      @(negedge clk);
      cfg_len       = 2'(len);
      cfg_stop      = 2'(stp);
      cfg_par_en    = (pm != 0);
      cfg_par_odd   = (pm == 1 || pm == 3);
      cfg_par_stick = (pm >= 3);
   endtask

   // drive a raw waveform on the receive line, LSB of bits first
   task automatic raw(logic [15:0] bits, int n);
      loop_en = 1'b0;
      for (int i = 0; i < n; i++) begin
         line_drv = bits[i];
         repeat (BIT) @(negedge clk);
      end
      line_drv = 1'b1;
      repeat (2 * BIT) @(negedge clk);
   endtask

   task automatic frame_len(int len, int stp, int pm);
      int cnt = 0;
      int expv;
      setcfg(len, stp, pm);
      send(8'h6B);
      while (!tx_busy) @(negedge clk);
      while (tx_busy) begin
         cnt++;
         @(negedge clk);
      end
      expv = ((1 + 5 + len + (pm != 0 ? 1 : 0)) * 16 + (stp == 0 ? 16 : stp == 1 ? 24 : 32)) * DIV;
      chk("R3 R4 frame length", 32'(cnt), 32'(expv));
      drain();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog (R1..) act=running exp=finished");
      report();
   end

   initial begin
      int low_seen;
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset tx_level", 32'(tx_level), 32'd0);
      chk("R1 reset rx_empty", 32'(rx_empty), 32'd1);
      chk("R1 reset txd", 32'(txd), 32'd1);
      chk("R8 reset hs_out", 32'(hs_out), 32'd1);

      // R2 R5 R6 loopback over every format
      for (int len = 0; len < 4; len++)
         for (int stp = 0; stp < 3; stp++)
            for (int pm = 0; pm < 5; pm++) begin
               setcfg(len, stp, pm);
               send(8'hA5 ^ 8'(len * 16 + stp * 4 + pm));
               send(8'h3C + 8'(pm * 17));
               drain();
            end

      // R4 frame lengths
      frame_len(3, 1, 1);
      frame_len(0, 0, 0);
      frame_len(2, 2, 0);
      frame_len(1, 3, 4);

      // R5 parity error: 8 bits, even, data 0x03 with parity bit 1
      setcfg(3, 0, 2);
      exp_q.push_back({3'b001, 8'h03});
      raw({5'b11111, 1'b1, 1'b1, 8'h03, 1'b0}, 11);
      drain();
      // R6 sticky odd expects constant 1: bit 0 flagged, bit 1 accepted
      setcfg(3, 0, 3);
      exp_q.push_back({3'b001, 8'h01});
      raw({5'b11111, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
      exp_q.push_back({3'b000, 8'h01});
      raw({5'b11111, 1'b1, 1'b1, 8'h01, 1'b0}, 11);
      drain();
      // R10 framing error: stop bit low
      setcfg(3, 0, 0);
      exp_q.push_back({3'b010, 8'h55});
      raw({6'b111111, 1'b0, 8'h55, 1'b0}, 10);
      drain();
      // R9 break: line low for 12 bit times
      exp_q.push_back({3'b100, 8'h00});
      raw(16'h0000, 12);
      drain();
      // R3 glitch shorter than half a bit
      loop_en = 1'b0;
      line_drv = 1'b0;
      repeat (4 * DIV) @(negedge clk);
      line_drv = 1'b1;
      repeat (20 * BIT) @(negedge clk);
      chk("R3 glitch rejected", 32'(rx_level), 32'd0);
      loop_en = 1'b1;

      // R1 R7 R8: gate transmit, overfill, release, watch receive threshold
      mon_en = 1'b0;
      setcfg(3, 0, 0);
      cfg_afc_tx = 1'b1;
      cfg_afc_rx = 1'b1;
      hs_in = 1'b0;
      for (int i = 0; i < 17; i++) begin
         if (i < 16) exp_q.push_back({3'b000, 8'(i * 7 + 1)});
         tx_wr = 1'b1;
         tx_data = 8'(i * 7 + 1);
         @(negedge clk);
      end
      tx_wr = 1'b0;
      low_seen = 0;
      for (int i = 0; i < 1500; i++) begin
         if (!txd) low_seen = 1;
         @(negedge clk);
      end
      chk("R7 line held while hs_in low", 32'(low_seen), 32'd0);
      chk("R1 tx_level full", 32'(tx_level), 32'd16);
      chk("R1 tx_full", 32'(tx_full), 32'd1);
      chk("R7 nothing received", 32'(rx_empty), 32'd1);
      hs_in = 1'b1;
      n = 0;
      while (rx_level != 16 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (2) @(negedge clk);
      chk("R1 rx_level full", 32'(rx_level), 32'd16);
      chk("R8 hs_out low at 16", 32'(hs_out), 32'd0);
      cfg_afc_rx = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 hs_out high with afc off", 32'(hs_out), 32'd1);
      cfg_afc_rx = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 hs_out low again", 32'(hs_out), 32'd0);
      pop_budget = 2;
      while (pop_budget > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R8 hs_out low at 14", 32'(hs_out), 32'd0);
      pop_budget = 1;
      while (pop_budget > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R8 hs_out high at 13", 32'(hs_out), 32'd1);
      mon_en = 1'b1;
      drain();
      cfg_afc_tx = 1'b0;
      cfg_afc_rx = 1'b0;
      chk("R11 queue emptied", 32'(rx_empty), 32'd1);
      report();
   end
endmodule